// File: doc/BRIEF.md
# Eight-Channel Block Transfer Sequencer

This block moves bytes between a 24-bit memory address (an 8-bit bank plus a 16-bit offset) and an 8-bit peripheral register address. Each of its eight channels holds its own control byte, peripheral base, memory bank, memory offset and byte count. Software programs these through a byte-wide register port. A pulse on `start` with a channel mask arms the channels whose mask bits are set.

Once started, the sequencer runs every armed channel in turn, lowest index first, and drains each channel's byte count before it moves on. Each byte appears as a one-cycle request carrying the memory address, the peripheral address and the direction. The peripheral address is the channel base plus an offset from a short repeating pattern chosen by the channel's mode. The memory offset can stay fixed, count up or count down. A cycle counter records the cycles spent: one for the whole run, one per armed channel and one per byte.

Top module: `bdma_engine`

## Requirements
- R1: A start pulse while idle sets the active flag of channel i from mask bit i; a start pulse while busy is ignored and adds no bytes.
- R2: Armed channels are served strictly from index 0 upward, and each channel moves all of its bytes before the next channel's first byte.
- R3: Every run lasts 1 + (armed channels) + (bytes moved) cycles. `cyc_cnt` clears on an accepted start, counts each busy cycle and then holds the total.
- R4: The peripheral address of byte k of a channel is base + P[mode][k mod 4], modulo 256, with k restarting at 0 for each channel. The patterns for modes 0..7 are {0,0,0,0}, {0,1,0,1}, {0,0,0,0}, {0,0,1,1}, {0,1,2,3}, {0,1,0,1}, {0,0,0,0} and {0,0,1,1}.
- R5: After each byte, the 16-bit memory offset is left alone when the fixed flag is set. Otherwise it decrements when the decrement flag is set and increments when it is clear, wrapping modulo 65536. The bank never changes, and the request address is {bank, offset}.
- R6: The byte count falls by one per byte and the channel stops when it reaches 0. A starting count of 0 moves 65536 bytes, and the count reads 0 after a channel completes.
- R7: Control byte fields: mode in bits 2:0, fixed in bit 3, decrement in bit 4, a spare bit 5, indirect in bit 6, and direction in bit 7 (1 = peripheral to memory). Bit 7 drives `xfer_b_to_a`, and all eight bits read back as written.
- R8: After reset, every channel register reads 0xFF (mode 7 with all flags set; base, bank, offset and count all ones). No channel is active, `busy` is 0 and `cyc_cnt` is 0.
- R9: `busy` is high from the cycle after an accepted start until the cycle after the last byte. A start with an empty mask gives exactly one busy cycle.
- R10: Writes to any register of a channel whose active flag is set are ignored.
- R11: The register address is {channel[2:0], index[3:0]}. The indices are: 0 control, 1 peripheral base, 2 offset low, 3 offset high, 4 bank, 5 count low, 6 count high. Other indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | {channel, register index} |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| start | input | 1 | Start pulse |
| start_mask | input | 8 | Channel enable mask, bit i for channel i |
| busy | output | 1 | Run in progress |
| xfer_req | output | 1 | One byte is moved this cycle |
| xfer_a_addr | output | 24 | Memory address {bank, offset} |
| xfer_b_addr | output | 8 | Peripheral register address |
| xfer_b_to_a | output | 1 | 1 = peripheral to memory |
| cyc_cnt | output | 24 | Cycles spent in the latest run |

## Verification
The hardest situation to reach is a start pulse or a register write that arrives in the middle of a running channel. The bench starts a multi-channel run, waits a few cycles, then fires a full-mask start and writes the active channel's base. It then checks that the byte stream, the cycle total and the read-back base are all unchanged. A count of zero is the other deep corner. It is reached by loading 0 into both count bytes and letting one channel move all 65536 bytes while the scoreboard follows each one.

// File: rtl/bdma_pkg.sv
package bdma_pkg;

   typedef struct packed {
      logic       b_to_a;
      logic       indirect;
      logic       spare;
      logic       dec;
      logic       fixed;
      logic [2:0] mode;
   } ctrl_t;

   typedef enum logic [3:0] {
      RI_CTRL  = 4'd0,
      RI_BBASE = 4'd1,
      RI_ALO   = 4'd2,
      RI_AHI   = 4'd3,
      RI_BANK  = 4'd4,
      RI_SLO   = 4'd5,
      RI_SHI   = 4'd6
   } reg_idx_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_GLOBAL,
      ST_CHAN,
      ST_BYTE
   } seq_st_e;

   // repeating peripheral-address step for each mode
   function automatic logic [1:0] b_offset(input logic [2:0] mode, input logic [1:0] k);
      logic [1:0] o;
      case (mode)
         3'd1, 3'd5: o = {1'b0, k[0]};
         3'd3, 3'd7: o = {1'b0, k[1]};
         3'd4:       o = k;
         default:    o = 2'd0;
      endcase
      return o;
   endfunction

endpackage

// File: rtl/bdma_chan.sv
module bdma_chan
   import bdma_pkg::*;
#(
   parameter int AOFFW = 16,
   parameter int SIZEW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [3:0]       wr_idx,
   input  logic [7:0]       wr_data,
   input  logic             arm,
   input  logic             arm_bit,
   input  logic             step,
   output ctrl_t            ctrl,
   output logic [7:0]       b_base,
   output logic [AOFFW-1:0] a_off,
   output logic [7:0]       bank,
   output logic [SIZEW-1:0] size,
   output logic             active
);

   localparam logic [SIZEW-1:0] SIZE_ONE = SIZEW'(1);

   if (AOFFW != 16 || SIZEW != 16) begin : g_width_bad
      $error("bdma_chan: offset and count must be two register bytes");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl   <= 8'hFF;
         b_base <= 8'hFF;
         a_off  <= '1;
         bank   <= 8'hFF;
         size   <= '1;
         active <= 1'b0;
      end else begin
         if (arm)
            active <= arm_bit;
         else if (step && size == SIZE_ONE)
            active <= 1'b0;

         if (step) begin
            if (!ctrl.fixed)
               a_off <= ctrl.dec ? a_off - 1'b1 : a_off + 1'b1;
            size <= size - 1'b1;
         end else if (wr_en && !active) begin
            case (wr_idx)
               RI_CTRL:  ctrl         <= wr_data;
               RI_BBASE: b_base       <= wr_data;
               RI_ALO:   a_off[7:0]   <= wr_data;
               RI_AHI:   a_off[15:8]  <= wr_data;
               RI_BANK:  bank         <= wr_data;
               RI_SLO:   size[7:0]    <= wr_data;
               RI_SHI:   size[15:8]   <= wr_data;
               default: ;
            endcase
         end
      end
   end

   // R6
   count_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> size == '0);
   // R5
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> $stable(bank));
   // R10
   locked_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> $stable(b_base) && $stable(ctrl) && $stable(bank));

endmodule

// File: rtl/bdma_seq.sv
module bdma_seq
   import bdma_pkg::*;
#(
   parameter int NCH  = 8,
   parameter int CNTW = 24,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [NCH-1:0]  active_vec,
   input  logic            last_byte,
   output logic            busy,
   output logic            arm,
   output logic            byte_en,
   output logic [CHW-1:0]  cur_ch,
   output logic [1:0]      idx,
   output logic [CNTW-1:0] cyc_cnt
);

   seq_st_e        state;
   logic [CHW-1:0] low_ch;
   logic [NCH-1:0] below_mask, other_mask;
   logic           any_act, more;

   always_comb begin
      low_ch = '0;
      for (int i = NCH - 1; i >= 0; i--)
         if (active_vec[i]) low_ch = CHW'(i);
   end

   always_comb begin
      for (int i = 0; i < NCH; i++) begin
         below_mask[i] = i < int'(cur_ch);
         other_mask[i] = i != int'(cur_ch);
      end
   end

   assign any_act = |active_vec;
   assign more    = |(active_vec & other_mask);
   assign busy    = state != ST_IDLE;
   assign arm     = start && state == ST_IDLE;
   assign byte_en = state == ST_BYTE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cur_ch  <= '0;
         idx     <= '0;
         cyc_cnt <= '0;
      end else begin
         if (arm)
            cyc_cnt <= '0;
         else if (busy)
            cyc_cnt <= cyc_cnt + 1'b1;

         case (state)
            ST_IDLE:   if (start) state <= ST_GLOBAL;
            ST_GLOBAL: state <= any_act ? ST_CHAN : ST_IDLE;
            ST_CHAN: begin
               cur_ch <= low_ch;
               idx    <= '0;
               state  <= ST_BYTE;
            end
            ST_BYTE: begin
               idx <= idx + 1'b1;
               if (last_byte) state <= more ? ST_CHAN : ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2
   order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_en |-> active_vec[cur_ch] && (active_vec & below_mask) == '0);
   // R3
   chan_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_en && $past(byte_en) |-> cur_ch == $past(cur_ch));

endmodule

// File: rtl/bdma_engine.sv
module bdma_engine
   import bdma_pkg::*;
#(
   parameter int NCH   = 8,
   parameter int CNTW  = 24,
   parameter int AOFFW = 16,
   parameter int SIZEW = 16,
   localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int RAW  = CHW + 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [RAW-1:0]   reg_addr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic             start,
   input  logic [NCH-1:0]   start_mask,
   output logic             busy,
   output logic             xfer_req,
   output logic [AOFFW+7:0] xfer_a_addr,
   output logic [7:0]       xfer_b_addr,
   output logic             xfer_b_to_a,
   output logic [CNTW-1:0]  cyc_cnt
);

   if (NCH < 1 || NCH > 8) begin : g_nch_bad
      $error("bdma_engine: NCH must be 1..8");
   end
   if (CNTW < 20) begin : g_cnt_bad
      $error("bdma_engine: CNTW too narrow for a 65536-byte channel");
   end

   ctrl_t            ctrl_a [NCH];
   logic [7:0]       bbase_a[NCH];
   logic [AOFFW-1:0] aoff_a [NCH];
   logic [7:0]       bank_a [NCH];
   logic [SIZEW-1:0] size_a [NCH];
   logic [NCH-1:0]   active_vec;

   logic           arm, byte_en, last_byte;
   logic [CHW-1:0] cur_ch;
   logic [1:0]     idx;
   logic [CHW-1:0] reg_ch;
   logic [3:0]     reg_idx;

   assign reg_ch  = reg_addr[RAW-1:4];
   assign reg_idx = reg_addr[3:0];

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      bdma_chan #(.AOFFW(AOFFW), .SIZEW(SIZEW)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_wr && int'(reg_ch) == g),
         .wr_idx  (reg_idx),
         .wr_data (reg_wdata),
         .arm     (arm),
         .arm_bit (start_mask[g]),
         .step    (byte_en && int'(cur_ch) == g),
         .ctrl    (ctrl_a[g]),
         .b_base  (bbase_a[g]),
         .a_off   (aoff_a[g]),
         .bank    (bank_a[g]),
         .size    (size_a[g]),
         .active  (active_vec[g])
      );
   end

   assign last_byte = size_a[cur_ch] == SIZEW'(1);

   bdma_seq #(.NCH(NCH), .CNTW(CNTW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .active_vec (active_vec),
      .last_byte  (last_byte),
      .busy       (busy),
      .arm        (arm),
      .byte_en    (byte_en),
      .cur_ch     (cur_ch),
      .idx        (idx),
      .cyc_cnt    (cyc_cnt)
   );

   assign xfer_req    = byte_en;
   assign xfer_a_addr = {bank_a[cur_ch], aoff_a[cur_ch]};
   assign xfer_b_addr = bbase_a[cur_ch] + {6'd0, b_offset(ctrl_a[cur_ch].mode, idx)};
   assign xfer_b_to_a = ctrl_a[cur_ch].b_to_a;

   always_comb begin
      reg_rdata = 8'h00;
      if (int'(reg_ch) < NCH) begin
         case (reg_idx)
            RI_CTRL:  reg_rdata = ctrl_a[reg_ch];
            RI_BBASE: reg_rdata = bbase_a[reg_ch];
            RI_ALO:   reg_rdata = aoff_a[reg_ch][7:0];
            RI_AHI:   reg_rdata = aoff_a[reg_ch][15:8];
            RI_BANK:  reg_rdata = bank_a[reg_ch];
            RI_SLO:   reg_rdata = size_a[reg_ch][7:0];
            RI_SHI:   reg_rdata = size_a[reg_ch][15:8];
            default:  reg_rdata = 8'h00;
         endcase
      end
   end

   // R9
   req_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> busy && $past(busy || start));
   // R1
   start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> active_vec == $past(start_mask));

endmodule

// File: tb/bdma_engine_bench.sv
`timescale 1ns/1ps
module bdma_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [6:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        start = 1'b0;
   logic [7:0]  start_mask = '0;
   logic        busy, xfer_req, xfer_b_to_a;
   logic [23:0] xfer_a_addr, cyc_cnt;
   logic [7:0]  xfer_b_addr;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   logic [32:0] exp_q[$];
   int m_ctrl[8], m_b[8], m_a[8], m_bank[8], m_size[8];
   int pat[8][4] = '{'{0,0,0,0}, '{0,1,0,1}, '{0,0,0,0}, '{0,0,1,1},
                     '{0,1,2,3}, '{0,1,0,1}, '{0,0,0,0}, '{0,0,1,1}};

   always #2.5 clk = ~clk;

   bdma_engine u_bdma_engine (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start(start),
      .start_mask(start_mask), .busy(busy), .xfer_req(xfer_req),
      .xfer_a_addr(xfer_a_addr), .xfer_b_addr(xfer_b_addr),
      .xfer_b_to_a(xfer_b_to_a), .cyc_cnt(cyc_cnt)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: compares each byte request with the queue head
   always @(negedge clk) begin
      if (rst_n && xfer_req) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R2 R6 extra byte actual 0x%0h expected none",
                     {xfer_b_to_a, xfer_a_addr, xfer_b_addr});
         end else begin
            logic [32:0] e;
            e = exp_q.pop_front();
            if ({xfer_b_to_a, xfer_a_addr, xfer_b_addr} !== e) begin
               errors++;
               $display("FAIL R4 R5 R7 byte actual 0x%0h expected 0x%0h",
                        {xfer_b_to_a, xfer_a_addr, xfer_b_addr}, e);
            end
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 190000 && !done) begin
         errors++;
         $display("FAIL watchdog actual %0d expected fewer cycles", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wr(int ch, int idx, int val);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = {ch[2:0], idx[3:0]}; reg_wdata = val[7:0];
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(string req, int ch, int idx, int exp);
      @(negedge clk);
      reg_addr = {ch[2:0], idx[3:0]};
      #1 check(req, int'(reg_rdata), exp);
   endtask

   task automatic prog(int ch, int c, int b, int a, int bk, int sz);
      wr(ch, 0, c); wr(ch, 1, b); wr(ch, 2, a & 255); wr(ch, 3, a >> 8);
      wr(ch, 4, bk); wr(ch, 5, sz & 255); wr(ch, 6, sz >> 8);
      m_ctrl[ch] = c; m_b[ch] = b; m_a[ch] = a; m_bank[ch] = bk; m_size[ch] = sz;
   endtask

   // driver: pushes expected bytes, then pulses start; returns expected cycles
   task automatic kick(int mask, output int exp_cyc);
      int nch = 0, bytes = 0;
      for (int ch = 0; ch < 8; ch++) begin
         if (mask[ch]) begin
            int n, a;
            n = (m_size[ch] == 0) ? 65536 : m_size[ch];
            a = m_a[ch];
            nch++; bytes += n;
            for (int k = 0; k < n; k++) begin
               logic [7:0] bb;
               bb = 8'(m_b[ch] + pat[m_ctrl[ch] & 7][k % 4]);
               exp_q.push_back({m_ctrl[ch][7], m_bank[ch][7:0], a[15:0], bb});
               if ((m_ctrl[ch] & 8) == 0)
                  a = (m_ctrl[ch] & 16) ? ((a - 1) & 16'hFFFF) : ((a + 1) & 16'hFFFF);
            end
            m_a[ch] = a; m_size[ch] = 0;
         end
      end
      exp_cyc = 1 + nch + bytes;
      @(negedge clk);
      start = 1'b1; start_mask = mask[7:0];
      @(negedge clk);
      start = 1'b0; start_mask = '0;
      check("R9 busy after start", int'(busy), 1);
   endtask

   task automatic finish_run(int exp_cyc, int mask);
      while (busy) @(negedge clk);
      check("R3 cycle total", int'(cyc_cnt), exp_cyc);
      check("R2 R6 all bytes seen", exp_q.size(), 0);
      for (int ch = 0; ch < 8; ch++) begin
         if (mask[ch]) begin
            rd("R6 count zero lo", ch, 5, 0);
            rd("R6 count zero hi", ch, 6, 0);
            rd("R5 offset lo", ch, 2, m_a[ch] & 255);
            rd("R5 offset hi", ch, 3, m_a[ch] >> 8);
            rd("R5 bank kept", ch, 4, m_bank[ch]);
         end
      end
   endtask

   initial begin
      int ec;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      check("R8 busy", int'(busy), 0);
      check("R8 req", int'(xfer_req), 0);
      check("R8 cyc_cnt", int'(cyc_cnt), 0);
      for (int idx = 0; idx < 7; idx++) rd("R8 R11 reset reg", 7, idx, 255);
      rd("R8 ch0 ctrl", 0, 0, 255);
      rd("R11 unused index", 0, 9, 0);

      // two channels, inc and dec, A to B
      prog(0, 8'h00, 8'h10, 16'h1234, 8'h7E, 3);
      prog(2, 8'h14, 8'hFE, 16'h0002, 8'h01, 6);
      rd("R7 ctrl readback", 2, 0, 8'h14);
      kick(8'h05, ec);
      finish_run(ec, 8'h05);

      // four channels, mixed modes, with start and writes mid-run
      prog(1, 8'h8B, 8'h40, 16'hAAAA, 8'h33, 5);
      prog(3, 8'h67, 8'h80, 16'hFFFE, 8'h44, 4);
      prog(5, 8'h15, 8'h00, 16'h0001, 8'h55, 2);
      prog(7, 8'h01, 8'hFF, 16'h0100, 8'h66, 3);
      rd("R7 spare and indirect bits", 3, 0, 8'h67);
      kick(8'hAA, ec);
      // R1 start while busy ignored
      @(negedge clk);
      start = 1'b1; start_mask = 8'hFF;
      @(negedge clk);
      start = 1'b0; start_mask = '0;
      // R10 write to an active channel ignored
      wr(7, 1, 8'h00);
      wr(7, 4, 8'h00);
      finish_run(ec, 8'hAA);
      rd("R10 base unchanged", 7, 1, 8'hFF);
      rd("R10 bank unchanged", 7, 4, 8'h66);
      check("R1 busy low", int'(busy), 0);

      // R9 empty mask gives one busy cycle
      kick(8'h00, ec);
      @(negedge clk);
      check("R9 empty mask idle", int'(busy), 0);
      check("R3 empty mask total", int'(cyc_cnt), 1);

      // R6 zero count moves 65536 bytes
      prog(6, 8'h0A, 8'h21, 16'h4000, 8'h09, 0);
      kick(8'h40, ec);
      finish_run(ec, 8'h40);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule